// File: doc/BRIEF.md
# Legacy PC System Control Ports

This block gathers three small control functions that a PC-compatible platform keeps on fixed I/O addresses. It sits on a simple 8-bit I/O bus with an address, a read strobe, a write strobe, write data and read data. It turns the values that software writes into side-band signals for the processor and for the real-time clock.

The first function is a combined register. It holds a global NMI mask bit and the 7-bit index that selects a location inside the real-time clock. The index field is hidden from ordinary reads of its main port. It can be read back through a second alias port, or while an alternate-access input is high. The second function is a fast A20 control bit, which is merged with an external A20 gate input. Next to it sits a software-started INIT pulse of fixed length. The third function is an acknowledge port for floating-point errors. An error input raises an interrupt line when it is enabled. A write of any value to the acknowledge port then asserts the ignore-numeric-error output, which holds until the error input falls.

All side-band outputs are active-high. Any inversion needed for active-low pins belongs outside the block.

Top module: `pc_sysctl_ports`

## Requirements
- R1: After reset: the NMI mask is 1, the RTC index is 0, the A20 bit and INIT bit are 0, and initOut, irq13Out and ignneOut are 0. A read of the alias port 74h returns 80h.
- R2: A write to 70h or to 74h loads bit 7 into nmiDisable and bits 6:0 into rtcIndex. Both outputs change in the cycle after the write.
- R3: A read of 70h with altAccess low returns the NMI mask in bit 7 and 0 in bits 6:0. With altAccess high, it returns the full stored byte.
- R4: A read of 74h returns the full stored byte {NMI mask, index}, whatever the value of altAccess.
- R5: A write to 92h stores bits 1:0. Bits 7:2 are discarded. A read of 92h returns {000000, A20 bit, INIT bit}.
- R6: a20Out is the OR of the stored A20 bit (bit 1 of 92h) and a20GateIn.
- R7: A write to 92h that takes bit 0 from 0 to 1 drives initOut high from the next cycle for exactly INIT_CLKS clock cycles (16 by default).
- R8: A write of 1 to bit 0 while bit 0 is already 1 starts no pulse. A 0-to-1 change of bit 0 during an active pulse neither restarts nor extends it.
- R9: While ferrIn is high and coprocErrEn is 1, irq13Out is high from the next cycle. While coprocErrEn is 0, ferrIn does not raise irq13Out.
- R10: A write to F0h, with any data value, sets ignneOut in the next cycle only if irq13Out is already high. Otherwise the write has no effect.
- R11: When ferrIn is low, irq13Out and ignneOut are both low from the next cycle. ignneOut holds until then.
- R12: A read of F0h or of any unimplemented address returns 00h. ioRdata is 00h whenever ioRd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ioAddr | input | 8 | I/O address |
| ioRd | input | 1 | Read strobe |
| ioWr | input | 1 | Write strobe |
| ioWdata | input | 8 | Write data |
| ioRdata | output | 8 | Read data (combinational) |
| altAccess | input | 1 | Alternate-access mode: exposes the index at 70h |
| nmiDisable | output | 1 | 1 masks all NMI sources |
| rtcIndex | output | 7 | Selected real-time-clock location |
| a20GateIn | input | 1 | External A20 gate request |
| a20Out | output | 1 | Merged A20 gate |
| initOut | output | 1 | Processor INIT pulse |
| ferrIn | input | 1 | Floating-point error from processor |
| coprocErrEn | input | 1 | Lets ferrIn raise irq13Out |
| irq13Out | output | 1 | Internal interrupt 13 request |
| ignneOut | output | 1 | Ignore numeric error |

## Verification
The bench measures the INIT pulse length at every cycle boundary. A counter that is off by one, or a pulse that ends at the wrong edge, shows up as 15 or 17 cycles. It also tries to retrigger the pulse, once with bit 0 already set and once by clearing and setting it during a pulse. A design that detects levels instead of edges, or that reloads its timer, gives a second rise or a longer pulse. The error path is driven with the enable off and with an acknowledge before any interrupt. A design that drops either qualifier raises ignneOut too early. The index readback is checked at 70h, with altAccess low and high, and at 74h. This catches a design that leaks the index or hides it at the alias.

// File: rtl/pc_sysctl_pkg.sv
package pc_sysctl_pkg;

  typedef enum logic [1:0] {
    RD_NONE     = 2'd0,
    RD_IDX_MASK = 2'd1,
    RD_IDX_FULL = 2'd2,
    RD_FAST     = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   wrIdx;
    logic   wrFast;
    logic   wrFerr;
    rdSel_e rdSel;
  } ctlStrobe_t;

endpackage

// File: rtl/pc_sysctl_ctrl.sv
module pc_sysctl_ctrl
  import pc_sysctl_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int INIT_CLKS  = 16,
  parameter logic [ADDR_W-1:0] PORT_IDX   = 8'h70,
  parameter logic [ADDR_W-1:0] PORT_ALIAS = 8'h74,
  parameter logic [ADDR_W-1:0] PORT_FAST  = 8'h92,
  parameter logic [ADDR_W-1:0] PORT_FERR  = 8'hF0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioRd,
  input  logic              ioWr,
  input  logic              wdataLsb,
  input  logic              initBitQ,
  input  logic              altAccess,
  input  logic              ferrIn,
  input  logic              coprocErrEn,
  output ctlStrobe_t        strb,
  output logic              initOut,
  output logic              irq13Out,
  output logic              ignneOut
);

  localparam int CNT_W = $clog2(INIT_CLKS + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(INIT_CLKS);

  logic hitIdx, hitAlias, hitFast, hitFerr;
  logic [CNT_W-1:0] initCnt;
  logic pulseBusy, startInit;
  logic irqQ, ignneQ;

  // address decode
  always_comb begin
    hitIdx   = (ioAddr == PORT_IDX);
    hitAlias = (ioAddr == PORT_ALIAS);
    hitFast  = (ioAddr == PORT_FAST);
    hitFerr  = (ioAddr == PORT_FERR);
  end

  always_comb begin
    strb.wrIdx  = ioWr && (hitIdx || hitAlias);
    strb.wrFast = ioWr && hitFast;
    strb.wrFerr = ioWr && hitFerr;
    strb.rdSel  = RD_NONE;
    if (ioRd) begin
      if (hitIdx)        strb.rdSel = altAccess ? RD_IDX_FULL : RD_IDX_MASK;
      else if (hitAlias) strb.rdSel = RD_IDX_FULL;
      else if (hitFast)  strb.rdSel = RD_FAST;
      else               strb.rdSel = RD_NONE;
    end
  end

  // INIT pulse sequencer
  assign pulseBusy = (initCnt != '0);
  assign startInit = strb.wrFast && wdataLsb && !initBitQ && !pulseBusy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initCnt <= '0;
    end else if (startInit) begin
      initCnt <= CNT_LOAD;
    end else if (pulseBusy) begin
      initCnt <= initCnt - 1'b1;
    end
  end

  assign initOut = pulseBusy;

  // floating-point error handshake
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqQ   <= 1'b0;
      ignneQ <= 1'b0;
    end else begin
      irqQ   <= ferrIn && (irqQ || coprocErrEn);
      ignneQ <= ferrIn && (ignneQ || (strb.wrFerr && irqQ));
    end
  end

  assign irq13Out = irqQ;
  assign ignneOut = ignneQ;

  AST_INIT_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(initOut) |-> $past(strb.wrFast && wdataLsb)); // R7
  AST_INIT_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(initOut) |-> $past(!initBitQ)); // R8
  AST_IRQ_NEEDS_FERR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq13Out) |-> $past(ferrIn && coprocErrEn)); // R9
  AST_IGNNE_NEEDS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ignneOut) |-> $past(irq13Out && strb.wrFerr)); // R10
  AST_FERR_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !ferrIn |=> (!irq13Out && !ignneOut)); // R11

endmodule

// File: rtl/pc_sysctl_dp.sv
module pc_sysctl_dp
  import pc_sysctl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [DATA_W-1:0] ioWdata,
  input  logic              a20GateIn,
  output logic [DATA_W-1:0] ioRdata,
  output logic              nmiDisable,
  output logic [DATA_W-2:0] rtcIndex,
  output logic              a20Out,
  output logic              initBitQ
);

  localparam int IDX_W = DATA_W - 1;
  localparam int RSV_W = DATA_W - 2;

  logic nmiQ;
  logic [IDX_W-1:0] idxQ;
  logic a20Q, initQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nmiQ <= 1'b1;
      idxQ <= '0;
    end else if (strb.wrIdx) begin
      nmiQ <= ioWdata[DATA_W-1];
      idxQ <= ioWdata[IDX_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      a20Q  <= 1'b0;
      initQ <= 1'b0;
    end else if (strb.wrFast) begin
      a20Q  <= ioWdata[1];
      initQ <= ioWdata[0];
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      RD_IDX_MASK: ioRdata = {nmiQ, {IDX_W{1'b0}}};
      RD_IDX_FULL: ioRdata = {nmiQ, idxQ};
      RD_FAST:     ioRdata = {{RSV_W{1'b0}}, a20Q, initQ};
      default:     ioRdata = '0;
    endcase
  end

  assign nmiDisable = nmiQ;
  assign rtcIndex   = idxQ;
  assign a20Out     = a20Q | a20GateIn;
  assign initBitQ   = initQ;

  AST_IDX_HIDDEN: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdSel == RD_IDX_MASK) |-> (ioRdata[IDX_W-1:0] == '0)); // R3
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdSel == RD_FAST) |-> (ioRdata[DATA_W-1:2] == '0)); // R5
  AST_IDX_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrIdx |=> (rtcIndex == $past(ioWdata[IDX_W-1:0]))); // R2

endmodule

// File: rtl/pc_sysctl_ports.sv
module pc_sysctl_ports
  import pc_sysctl_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int INIT_CLKS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioRd,
  input  logic              ioWr,
  input  logic [DATA_W-1:0] ioWdata,
  output logic [DATA_W-1:0] ioRdata,
  input  logic              altAccess,
  output logic              nmiDisable,
  output logic [DATA_W-2:0] rtcIndex,
  input  logic              a20GateIn,
  output logic              a20Out,
  output logic              initOut,
  input  logic              ferrIn,
  input  logic              coprocErrEn,
  output logic              irq13Out,
  output logic              ignneOut
);

  ctlStrobe_t strb;
  logic initBitQ;

  pc_sysctl_ctrl #(
    .ADDR_W(ADDR_W), .INIT_CLKS(INIT_CLKS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioRd(ioRd), .ioWr(ioWr),
    .wdataLsb(ioWdata[0]), .initBitQ(initBitQ), .altAccess(altAccess),
    .ferrIn(ferrIn), .coprocErrEn(coprocErrEn), .strb(strb),
    .initOut(initOut), .irq13Out(irq13Out), .ignneOut(ignneOut)
  );

  pc_sysctl_dp #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ioWdata(ioWdata),
    .a20GateIn(a20GateIn), .ioRdata(ioRdata), .nmiDisable(nmiDisable),
    .rtcIndex(rtcIndex), .a20Out(a20Out), .initBitQ(initBitQ)
  );

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !ioRd |-> (ioRdata == '0)); // R12

endmodule

// File: tb/pc_sysctl_ports_test.sv
module pc_sysctl_ports_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] ioAddr = '0;
  logic ioRd = 1'b0, ioWr = 1'b0;
  logic [7:0] ioWdata = '0;
  logic [7:0] ioRdata;
  logic altAccess = 1'b0, a20GateIn = 1'b0, ferrIn = 1'b0, coprocErrEn = 1'b0;
  logic nmiDisable, a20Out, initOut, irq13Out, ignneOut;
  logic [6:0] rtcIndex;

  int checks = 0;
  int failures = 0;
  int highCycles = 0;
  int rises = 0;
  logic prevInit = 1'b0;
  logic timedOut = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } rdItem_t;
  rdItem_t expQ[$];

  always #10 clk = ~clk; // 50 MHz

  pc_sysctl_ports uut (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioRd(ioRd), .ioWr(ioWr),
    .ioWdata(ioWdata), .ioRdata(ioRdata), .altAccess(altAccess),
    .nmiDisable(nmiDisable), .rtcIndex(rtcIndex), .a20GateIn(a20GateIn),
    .a20Out(a20Out), .initOut(initOut), .ferrIn(ferrIn),
    .coprocErrEn(coprocErrEn), .irq13Out(irq13Out), .ignneOut(ignneOut)
  );

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops scoreboard on every read cycle, plus INIT pulse tracking
  always @(negedge clk) begin
    if (ioRd && expQ.size() > 0) begin
      rdItem_t it;
      it = expQ.pop_front();
      checkEq(it.tag, 32'(ioRdata), 32'(it.exp));
    end
    if (initOut) highCycles++;
    if (initOut && !prevInit) rises++;
    prevInit = initOut;
  end

  task automatic busWrite(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    ioAddr = a; ioWdata = d; ioWr = 1'b1;
    @(posedge clk); #2;
    ioWr = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, input logic [7:0] exp, input string tag);
    rdItem_t it;
    @(posedge clk); #2;
    it.exp = exp; it.tag = tag;
    expQ.push_back(it);
    ioAddr = a; ioRd = 1'b1;
    @(posedge clk); #2;
    ioRd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic runTests();
    // R1 reset state
    @(negedge clk);
    checkEq("R1 nmiDisable", 32'(nmiDisable), 32'd1);
    checkEq("R1 rtcIndex", 32'(rtcIndex), 32'd0);
    checkEq("R1 initOut", 32'(initOut), 32'd0);
    checkEq("R1 irq13Out", 32'(irq13Out), 32'd0);
    checkEq("R1 ignneOut", 32'(ignneOut), 32'd0);
    checkEq("R1 a20Out", 32'(a20Out), 32'd0);
    busRead(8'h74, 8'h80, "R1 alias reset");
    busRead(8'h92, 8'h00, "R1 fast reset");

    // R2 / R3 / R4 index register
    busWrite(8'h70, 8'h35);
    @(negedge clk);
    checkEq("R2 nmiDisable 70h", 32'(nmiDisable), 32'd0);
    checkEq("R2 rtcIndex 70h", 32'(rtcIndex), 32'h35);
    busRead(8'h70, 8'h00, "R3 70h normal hides index");
    altAccess = 1'b1;
    busRead(8'h70, 8'h35, "R3 70h alt full");
    altAccess = 1'b0;
    busRead(8'h74, 8'h35, "R4 74h full");
    busWrite(8'h74, 8'hCA);
    @(negedge clk);
    checkEq("R2 nmiDisable 74h", 32'(nmiDisable), 32'd1);
    checkEq("R2 rtcIndex 74h", 32'(rtcIndex), 32'h4A);
    busRead(8'h70, 8'h80, "R3 70h normal mask only");
    altAccess = 1'b1;
    busRead(8'h74, 8'hCA, "R4 74h in alt");
    altAccess = 1'b0;

    // R6 A20 merge
    a20GateIn = 1'b1; #1;
    checkEq("R6 gate only", 32'(a20Out), 32'd1);
    a20GateIn = 1'b0;
    busWrite(8'h92, 8'h02);
    @(negedge clk);
    checkEq("R6 bit only", 32'(a20Out), 32'd1);
    busRead(8'h92, 8'h02, "R5 read a20 bit");
    busWrite(8'h92, 8'h00);
    @(negedge clk);
    checkEq("R6 both low", 32'(a20Out), 32'd0);
    checkEq("R8 no pulse on 0 write", 32'(rises), 32'd0);

    // R7 pulse length
    idle(1); highCycles = 0; rises = 0;
    busWrite(8'h92, 8'h01);
    @(negedge clk);
    checkEq("R7 initOut after write", 32'(initOut), 32'd1);
    idle(30);
    checkEq("R7 pulse length", 32'(highCycles), 32'd16);
    checkEq("R7 one rise", 32'(rises), 32'd1);

    // R8 rewrite of 1 with bit already set; R5 reserved bits
    highCycles = 0; rises = 0;
    busWrite(8'h92, 8'hFD);
    idle(20);
    checkEq("R8 set-while-set no pulse", 32'(rises), 32'd0);
    busRead(8'h92, 8'h01, "R5 reserved discarded");

    // R8 re-edge during active pulse
    busWrite(8'h92, 8'h00);
    idle(1); highCycles = 0; rises = 0;
    busWrite(8'h92, 8'h01);
    busWrite(8'h92, 8'h00);
    busWrite(8'h92, 8'h01);
    idle(30);
    checkEq("R8 retrigger length", 32'(highCycles), 32'd16);
    checkEq("R8 retrigger rises", 32'(rises), 32'd1);

    // R9 / R10 / R11 error handshake
    ferrIn = 1'b1; coprocErrEn = 1'b0;
    idle(3);
    @(negedge clk);
    checkEq("R9 disabled no irq", 32'(irq13Out), 32'd0);
    busWrite(8'hF0, 8'h00);
    @(negedge clk);
    checkEq("R10 ack without irq", 32'(ignneOut), 32'd0);
    ferrIn = 1'b0;
    idle(2);
    coprocErrEn = 1'b1; ferrIn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    checkEq("R9 irq raised", 32'(irq13Out), 32'd1);
    checkEq("R10 no ignne before ack", 32'(ignneOut), 32'd0);
    busWrite(8'hF0, 8'h5A);
    @(negedge clk);
    checkEq("R10 ignne after ack", 32'(ignneOut), 32'd1);
    idle(4);
    @(negedge clk);
    checkEq("R11 ignne holds", 32'(ignneOut), 32'd1);
    #8 ferrIn = 1'b0;
    @(posedge clk);
    @(negedge clk);
    checkEq("R11 irq cleared", 32'(irq13Out), 32'd0);
    checkEq("R11 ignne cleared", 32'(ignneOut), 32'd0);

    // R12 unimplemented reads
    busRead(8'hF0, 8'h00, "R12 F0 read");
    busRead(8'h71, 8'h00, "R12 unmapped read");
    @(negedge clk);
    checkEq("R12 idle rdata", 32'(ioRdata), 32'd0);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    fork
      runTests();
      begin
        repeat (20000) @(posedge clk);
        timedOut = 1'b1;
      end
    join_any
    disable fork;
    if (timedOut) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule